// File: doc/BRIEF.md
# Host Mailbox Command Sequencer

This block is a host-side engine that carries out one command exchange with a device through a small register mailbox. It acts as a master on a simple request/acknowledge register bus. A request holds an opcode, a queue index, a byte length and a flag that says whether the command returns a payload. The engine waits until the mailbox is free and then posts the command. When a payload is expected, it pulls the payload chunk by chunk and streams each 32-bit word out. It hands each chunk back to the device, waits for the device to retire the command, and then reports a status.

The mailbox has three parts. Word address 0 is the command word. Word address 1 is the control word. Data words start at word address 3. Every wait is a poll loop: a read, a gap of idle cycles, then another read. A wait that outlasts its cycle budget ends the request with a timeout status. A single-register legacy mode posts only the opcode and waits for the device to clear it.

Top module: `mbox_cmd_seq`

## Requirements
- R1: A request whose byte length has either of bits 1:0 set returns status 3 (bad length), and the engine makes no bus access for it.
- R2: In normal mode the engine first polls the control word (word address 1) and writes nothing until a read shows in-progress (bit 16) clear or a nonzero error field (bits 27:18). It then writes the control word first and the command word second.
- R3: The control word is written with the request's word count (byte length divided by 4) for a payload request and with 0 for a message. The command word is written as queue index in bits 31:16 and opcode in bits 15:0.
- R4: The data wait polls the control word until chunk-ready (bit 17) or a nonzero error field is seen. A nonzero error field ends the request with status 2 and that 10-bit code on the code output. The code output is 0 for every other status.
- R5: Each chunk yields the lesser of the size field (bits 15:0) and the words still owed. These words are read from data word address 3 upward and appear in order on the output stream. A message never yields words.
- R6: After a payload chunk whose control read showed in-progress clear, the engine goes straight to the final wait. Otherwise it writes the control word back as read with bit 17 cleared, and it fetches another chunk only while words are still owed. A message always writes back once.
- R7: The final wait polls the command word (word address 0) until it reads zero and then returns status 0. A zero-length payload request goes to this wait directly after the command write.
- R8: Successive polls within one wait are at least POLL_GAP cycles apart. A wait that has run TIMEOUT_CYC cycles without success ends with status 1.
- R9: In legacy mode the engine polls the command word until it is zero, writes the opcode with bits 31:16 zero, and polls until it is zero again. It never touches the control word.
- R10: Request-ready is low from the cycle after acceptance until the request completes. Completion is a one-cycle done pulse.
- R11: A bus access holds its request, direction, address and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Engine idle, request taken when valid |
| reqOpcode | input | 16 | Command opcode |
| reqQueue | input | 16 | Queue index carried with the command |
| reqBytes | input | LEN_W | Payload buffer length in bytes |
| reqPayload | input | 1 | 1: command returns payload, 0: message |
| reqLegacy | input | 1 | Use single-register legacy exchange |
| busReq | output | 1 | Bus access pending |
| busWrite | output | 1 | 1 write, 0 read |
| busAddr | output | ADDR_W | Word address |
| busWdata | output | 32 | Write data |
| busAck | input | 1 | Access completed this cycle |
| busRdata | input | 32 | Read data, valid with busAck |
| outValid | output | 1 | Payload word valid |
| outData | output | 32 | Payload word |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 2 | 0 ok, 1 timeout, 2 device error, 3 bad length |
| doneCode | output | 10 | Device error code |

## Verification
The assertions check the following on every cycle: bus accesses stay stable until they are acknowledged, request-ready drops after acceptance, done lasts one cycle, a bad length leads straight to done with no bus access, a timeout status comes only after the wait budget is spent, and a word is taken only while the chunk still owes one. Other properties need whole exchanges against a scripted device. Examples are the clamping of a chunk to the words still owed, the early stop on a cleared in-progress flag, the exact write-back values, the ordering of writes, the legacy exchange, and the spacing of polls. Only the bench scenarios can show these.

// File: rtl/mbox_seq_pkg.sv
package mbox_seq_pkg;
  localparam int SIZE_W     = 16;
  localparam int INPROG_BIT = 16;
  localparam int READY_BIT  = 17;
  localparam int ERR_LSB    = 18;
  localparam int ERR_W      = 10;
  localparam int OP_ADDR    = 0;
  localparam int CTRL_ADDR  = 1;
  localparam int DATA_BASE  = 3;

  typedef enum logic [1:0] {
    ST_OK = 2'd0, ST_TIMEOUT = 2'd1, ST_DEVERR = 2'd2, ST_BADLEN = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    BUS_NONE, BUS_RD_CTRL, BUS_RD_OP, BUS_WR_CTRL, BUS_WR_OP, BUS_RD_DATA, BUS_WR_BACK
  } bussel_e;

  typedef struct packed {
    logic    load;
    logic    startWait;
    logic    waiting;
    logic    inGap;
    logic    restartGap;
    logic    latchCtrl;
    logic    takeWord;
    bussel_e busSel;
  } strobe_t;
endpackage

// File: rtl/mbox_seq_dp.sv
module mbox_seq_dp
  import mbox_seq_pkg::*;
#(
  parameter int LEN_W       = 18,
  parameter int ADDR_W      = 16,
  parameter int TIMEOUT_CYC = 500000000,
  parameter int POLL_GAP    = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [15:0]       reqOpcode,
  input  logic [15:0]       reqQueue,
  input  logic [LEN_W-1:0]  reqBytes,
  input  logic              reqPayload,
  input  logic              reqLegacy,
  input  logic              busAck,
  input  logic [31:0]       busRdata,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  output logic              outValid,
  output logic [31:0]       outData,
  output logic              remZero,
  output logic              chunkZero,
  output logic              latInProg,
  output logic [ERR_W-1:0]  latErr,
  output logic              timerExpired,
  output logic              gapDone
);
  localparam int WORD_W = LEN_W - 2;
  localparam int CNT_W  = (WORD_W > SIZE_W) ? WORD_W : SIZE_W;
  localparam int TMR_W  = $clog2(TIMEOUT_CYC + POLL_GAP + 4) + 1;
  localparam int GAP_W  = $clog2(POLL_GAP + 1) + 1;

  logic [15:0]       opcodeQ, queueQ;
  logic              legacyQ;
  logic [WORD_W-1:0] remQ;
  logic [CNT_W-1:0]  chunkQ, idxQ;
  logic [31:0]       ctrlQ;
  logic [TMR_W-1:0]  timerQ;
  logic [GAP_W-1:0]  gapQ;
  logic [CNT_W-1:0]  sizeExt, remExt;

  assign sizeExt = CNT_W'(busRdata[SIZE_W-1:0]);
  assign remExt  = CNT_W'(remQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeQ  <= '0;
      queueQ   <= '0;
      legacyQ  <= 1'b0;
      remQ     <= '0;
      chunkQ   <= '0;
      idxQ     <= '0;
      ctrlQ    <= '0;
      timerQ   <= '0;
      gapQ     <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= 1'b0;
      if (strb.load) begin
        opcodeQ <= reqOpcode;
        queueQ  <= reqQueue;
        legacyQ <= reqLegacy;
        remQ    <= reqPayload ? reqBytes[LEN_W-1:2] : '0;
      end
      if (strb.latchCtrl) begin
        ctrlQ  <= busRdata;
        chunkQ <= (sizeExt < remExt) ? sizeExt : remExt;
        idxQ   <= '0;
      end
      if (strb.takeWord) begin
        idxQ     <= idxQ + 1'b1;
        chunkQ   <= chunkQ - 1'b1;
        remQ     <= remQ - 1'b1;
        outValid <= 1'b1;
        outData  <= busRdata;
      end
      if (strb.startWait) timerQ <= '0;
      else if (strb.waiting && !(&timerQ)) timerQ <= timerQ + 1'b1;
      if (strb.restartGap) gapQ <= '0;
      else if (strb.inGap && !gapDone) gapQ <= gapQ + 1'b1;
    end
  end

  assign remZero      = (remQ == '0);
  assign chunkZero    = (chunkQ == '0);
  assign latInProg    = ctrlQ[INPROG_BIT];
  assign latErr       = ctrlQ[ERR_LSB +: ERR_W];
  assign timerExpired = (timerQ >= TMR_W'(TIMEOUT_CYC));
  assign gapDone      = (gapQ >= GAP_W'(POLL_GAP - 1));

  always_comb begin
    busReq   = (strb.busSel != BUS_NONE);
    busWrite = 1'b0;
    busAddr  = ADDR_W'(CTRL_ADDR);
    busWdata = '0;
    unique case (strb.busSel)
      BUS_RD_OP:   busAddr = ADDR_W'(OP_ADDR);
      BUS_WR_CTRL: begin busWrite = 1'b1; busWdata = 32'(remQ); end
      BUS_WR_OP: begin
        busWrite = 1'b1;
        busAddr  = ADDR_W'(OP_ADDR);
        busWdata = legacyQ ? {16'h0, opcodeQ} : {queueQ, opcodeQ};
      end
      BUS_RD_DATA: busAddr = ADDR_W'(DATA_BASE) + ADDR_W'(idxQ);
      BUS_WR_BACK: begin busWrite = 1'b1; busWdata = ctrlQ & ~(32'h1 << READY_BIT); end
      default: ;
    endcase
  end

  a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWdata) && $stable(busWrite));

  a_r5_word_within_chunk: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeWord |-> (chunkQ != '0) && busAck);
endmodule

// File: rtl/mbox_seq_ctrl.sv
module mbox_seq_ctrl
  import mbox_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqBytesLow,
  input  logic        reqPayload,
  input  logic        reqLegacy,
  input  logic        busAck,
  input  logic [31:0] busRdata,
  input  logic        remZero,
  input  logic        chunkZero,
  input  logic        latInProg,
  input  logic        timerExpired,
  input  logic        gapDone,
  output logic        reqReady,
  output strobe_t     strb,
  output logic        doneValid,
  output status_e     doneStatus
);
  typedef enum logic [2:0] {S_IDLE, S_POLL, S_GAP, S_WCTRL, S_WOP, S_RDATA, S_WBACK, S_DONE} state_e;
  typedef enum logic [2:0] {K_IDLE, K_DATA, K_OPCLR, K_LEG0, K_LEG1} kind_e;

  state_e  stateQ, stateN;
  kind_e   kindQ, kindN;
  status_e statusQ, statusN;
  logic    payloadQ, legacyQ;
  logic    rdErr, met;

  assign rdErr = (busRdata[ERR_LSB +: ERR_W] != '0);

  always_comb begin
    unique case (kindQ)
      K_IDLE:  met = rdErr || !busRdata[INPROG_BIT];
      K_DATA:  met = rdErr || busRdata[READY_BIT];
      default: met = (busRdata == '0);
    endcase
  end

  always_comb begin
    stateN  = stateQ;
    kindN   = kindQ;
    statusN = statusQ;
    strb    = '0;
    strb.busSel = BUS_NONE;
    unique case (stateQ)
      S_IDLE: if (reqValid) begin
        strb.load = 1'b1;
        if (reqBytesLow != 2'b00) begin
          statusN = ST_BADLEN;
          stateN  = S_DONE;
        end else begin
          strb.startWait = 1'b1;
          kindN  = reqLegacy ? K_LEG0 : K_IDLE;
          stateN = S_POLL;
        end
      end
      S_POLL: begin
        strb.waiting = 1'b1;
        strb.busSel  = (kindQ == K_IDLE || kindQ == K_DATA) ? BUS_RD_CTRL : BUS_RD_OP;
        if (busAck) begin
          if (met) begin
            unique case (kindQ)
              K_IDLE: stateN = S_WCTRL;
              K_LEG0: stateN = S_WOP;
              K_DATA: begin
                strb.latchCtrl = 1'b1;
                if (rdErr) begin statusN = ST_DEVERR; stateN = S_DONE; end
                else stateN = S_RDATA;
              end
              default: begin statusN = ST_OK; stateN = S_DONE; end
            endcase
          end else if (timerExpired) begin
            statusN = ST_TIMEOUT;
            stateN  = S_DONE;
          end else begin
            strb.restartGap = 1'b1;
            stateN = S_GAP;
          end
        end
      end
      S_GAP: begin
        strb.waiting = 1'b1;
        strb.inGap   = 1'b1;
        if (gapDone) stateN = S_POLL;
      end
      S_WCTRL: begin
        strb.busSel = BUS_WR_CTRL;
        if (busAck) stateN = S_WOP;
      end
      S_WOP: begin
        strb.busSel = BUS_WR_OP;
        if (busAck) begin
          strb.startWait = 1'b1;
          stateN = S_POLL;
          if (legacyQ) kindN = K_LEG1;
          else if (payloadQ && remZero) kindN = K_OPCLR;
          else kindN = K_DATA;
        end
      end
      S_RDATA: begin
        if (!chunkZero) begin
          strb.busSel   = BUS_RD_DATA;
          strb.takeWord = busAck;
        end else if (payloadQ && !latInProg) begin
          strb.startWait = 1'b1;
          kindN  = K_OPCLR;
          stateN = S_POLL;
        end else begin
          stateN = S_WBACK;
        end
      end
      S_WBACK: begin
        strb.busSel = BUS_WR_BACK;
        if (busAck) begin
          strb.startWait = 1'b1;
          kindN  = (!payloadQ || remZero) ? K_OPCLR : K_DATA;
          stateN = S_POLL;
        end
      end
      S_DONE: stateN = S_IDLE;
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= S_IDLE;
      kindQ    <= K_IDLE;
      statusQ  <= ST_OK;
      payloadQ <= 1'b0;
      legacyQ  <= 1'b0;
    end else begin
      stateQ  <= stateN;
      kindQ   <= kindN;
      statusQ <= statusN;
      if (strb.load) begin
        payloadQ <= reqPayload;
        legacyQ  <= reqLegacy;
      end
    end
  end

  assign reqReady   = (stateQ == S_IDLE);
  assign doneValid  = (stateQ == S_DONE);
  assign doneStatus = statusQ;

  a_r10_single_request: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  a_r1_badlen_no_bus: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && (reqBytesLow != 2'b00)
      |=> (strb.busSel == BUS_NONE) && doneValid && (doneStatus == ST_BADLEN));

  a_r8_timeout_after_budget: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && (doneStatus == ST_TIMEOUT) |-> timerExpired);
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
  import mbox_seq_pkg::*;
#(
  parameter int LEN_W       = 18,
  parameter int ADDR_W      = 16,
  parameter int TIMEOUT_CYC = 500000000,
  parameter int POLL_GAP    = 2500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [15:0]       reqOpcode,
  input  logic [15:0]       reqQueue,
  input  logic [LEN_W-1:0]  reqBytes,
  input  logic              reqPayload,
  input  logic              reqLegacy,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       busWdata,
  input  logic              busAck,
  input  logic [31:0]       busRdata,
  output logic              outValid,
  output logic [31:0]       outData,
  output logic              doneValid,
  output logic [1:0]        doneStatus,
  output logic [9:0]        doneCode
);
  strobe_t          strb;
  status_e          status;
  logic             remZero, chunkZero, latInProg, timerExpired, gapDone;
  logic [ERR_W-1:0] latErr;

  mbox_seq_ctrl u_ctrl (
    .clk, .rstN, .reqValid,
    .reqBytesLow(reqBytes[1:0]),
    .reqPayload, .reqLegacy, .busAck, .busRdata,
    .remZero, .chunkZero, .latInProg, .timerExpired, .gapDone,
    .reqReady, .strb, .doneValid,
    .doneStatus(status)
  );

  mbox_seq_dp #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .TIMEOUT_CYC(TIMEOUT_CYC), .POLL_GAP(POLL_GAP)
  ) u_dp (
    .clk, .rstN, .strb, .reqOpcode, .reqQueue, .reqBytes, .reqPayload, .reqLegacy,
    .busAck, .busRdata, .busReq, .busWrite, .busAddr, .busWdata,
    .outValid, .outData, .remZero, .chunkZero, .latInProg, .latErr,
    .timerExpired, .gapDone
  );

  assign doneStatus = status;
  assign doneCode   = (status == ST_DEVERR) ? latErr : '0;
endmodule

// File: tb/mbox_cmd_seq_test.sv
module mbox_cmd_seq_test;
  localparam int TO  = 120;
  localparam int GAP = 5;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        reqValid = 1'b0, reqReady;
  logic [15:0] reqOpcode = '0, reqQueue = '0;
  logic [17:0] reqBytes = '0;
  logic        reqPayload = 1'b0, reqLegacy = 1'b0;
  logic        busReq, busWrite, busAck = 1'b0;
  logic [15:0] busAddr;
  logic [31:0] busWdata, busRdata = '0, outData;
  logic        outValid, doneValid;
  logic [1:0]  doneStatus;
  logic [9:0]  doneCode;

  always #2 clk = ~clk;

  mbox_cmd_seq #(.LEN_W(18), .ADDR_W(16), .TIMEOUT_CYC(TO), .POLL_GAP(GAP)) uut (
    .clk, .rstN, .reqValid, .reqReady, .reqOpcode, .reqQueue, .reqBytes, .reqPayload,
    .reqLegacy, .busReq, .busWrite, .busAddr, .busWdata, .busAck, .busRdata,
    .outValid, .outData, .doneValid, .doneStatus, .doneCode
  );

  int checks = 0, fails = 0;
  logic [31:0] expWords[$];
  int          expWrA[$];
  logic [31:0] expWrD[$];
  int chSize[4], chLast[4], chErr[4];
  int nChunks, chIdx, readyNow, devPhase, busyPolls, opHold, opHoldAfter;
  int opPolls, lastOpPoll, gapViol, busCount, cycle, r2Viol, r10Viol;
  bit gotDone, inReq;
  logic [1:0] gotStatus;
  logic [9:0] gotCode;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] chunkWord(input int c);
    return (32'(chErr[c]) << 18) | (32'h1 << 17) | ((chLast[c] != 0) ? 32'h0 : 32'h1 << 16)
           | 32'(chSize[c]);
  endfunction

  task automatic devReset();
    busyPolls = 0; nChunks = 0; chIdx = 0; readyNow = 0; devPhase = 0;
    opHold = 0; opHoldAfter = 0; opPolls = 0; lastOpPoll = -1; gapViol = 0;
    r2Viol = 0;
    expWords.delete(); expWrA.delete(); expWrD.delete();
  endtask

  // scripted device plus per-clock comparison against the expected queues
  initial begin
    cycle = 0;
    @(posedge rstN);
    forever begin
      @(negedge clk);
      cycle++;
      if (outValid) begin
        if (expWords.size() == 0) check(1'b0, "R5", "unexpected word", outData, 32'h0);
        else begin
          logic [31:0] e;
          e = expWords.pop_front();
          check(outData == e, "R5", "stream word", outData, e);
        end
      end
      if (inReq && reqReady && !gotDone) r10Viol++;
      if (doneValid) begin
        gotDone = 1'b1; gotStatus = doneStatus; gotCode = doneCode;
      end
      if (busAck) begin
        busAck = 1'b0;
      end else if (busReq) begin
        busCount++;
        busRdata = '0;
        if (busWrite) begin
          if (expWrA.size() == 0) check(1'b0, "R3", "unexpected write", busWdata, 32'(busAddr));
          else begin
            int a; logic [31:0] d;
            a = expWrA.pop_front(); d = expWrD.pop_front();
            check(int'(busAddr) == a, "R6", "write address", 32'(busAddr), 32'(a));
            check(busWdata == d, "R3", "write data", busWdata, d);
          end
          if (busAddr == 16'd1) begin
            if (devPhase == 0 && busyPolls > 0) r2Viol++;
            if (devPhase == 1) begin chIdx++; readyNow = 0; end
          end else if (busAddr == 16'd0) begin
            devPhase = 1; opHold = opHoldAfter; chIdx = 0; readyNow = 0; lastOpPoll = -1;
          end
        end else begin
          if (busAddr == 16'd1) begin
            if (devPhase == 0) begin
              if (busyPolls > 0) begin busyPolls--; busRdata = 32'h1 << 16; end
            end else if (chIdx >= nChunks || readyNow == 0) begin
              readyNow = 1; busRdata = 32'h1 << 16;
            end else busRdata = chunkWord(chIdx);
          end else if (busAddr == 16'd0) begin
            opPolls++;
            if (lastOpPoll >= 0 && cycle - lastOpPoll < GAP) gapViol++;
            lastOpPoll = cycle;
            if (opHold > 0) begin opHold--; busRdata = 32'h1; end
          end else begin
            busRdata = 32'hD000_0000 | (32'(chIdx) << 8) | 32'(int'(busAddr) - 3);
          end
        end
        busAck = 1'b1;
      end
    end
  end

  task automatic run(input logic [15:0] op, input logic [15:0] q, input int bytes,
                     input bit pay, input bit leg, input logic [1:0] expSt,
                     input logic [9:0] expCode, input string req);
    busCount = 0; gotDone = 1'b0; r10Viol = 0;
    @(negedge clk);
    reqValid = 1'b1; reqOpcode = op; reqQueue = q; reqBytes = 18'(bytes);
    reqPayload = pay; reqLegacy = leg;
    @(negedge clk);
    reqValid = 1'b0; inReq = 1'b1;
    for (int i = 0; i < 4000 && !gotDone; i++) @(negedge clk);
    inReq = 1'b0;
    check(gotDone, "R10", "completion seen", 32'(gotDone), 32'h1);
    check(gotStatus == expSt, req, "status", 32'(gotStatus), 32'(expSt));
    check(gotCode == expCode, "R4", "error code", 32'(gotCode), 32'(expCode));
    check(expWords.size() == 0, "R5", "words outstanding", 32'(expWords.size()), 32'h0);
    check(expWrA.size() == 0, "R3", "writes outstanding", 32'(expWrA.size()), 32'h0);
    check(r10Viol == 0, "R10", "ready during request", 32'(r10Viol), 32'h0);
    check(r2Viol == 0, "R2", "write before idle", 32'(r2Viol), 32'h0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog: got %h expected %h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    devReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R10", "reset ready", 32'(reqReady), 32'h1);
    check(busReq == 1'b0, "R11", "reset bus idle", 32'(busReq), 32'h0);
    check(outValid == 1'b0 && doneValid == 1'b0, "R10", "reset outputs", 32'({outValid, doneValid}), 32'h0);

    // R1: bad length, no bus access
    devReset();
    run(16'h1, 16'h0, 6, 1'b1, 1'b0, 2'd3, 10'h0, "R1");
    check(busCount == 0, "R1", "bus accesses", 32'(busCount), 32'h0);

    // R2 R5 R6: two full chunks of two words, device busy at first
    devReset();
    busyPolls = 2; nChunks = 2; opHoldAfter = 2;
    chSize[0] = 2; chLast[0] = 0; chErr[0] = 0;
    chSize[1] = 2; chLast[1] = 0; chErr[1] = 0;
    expWrA.push_back(1); expWrD.push_back(32'd4);
    expWrA.push_back(0); expWrD.push_back(32'h0005_0002);
    expWrA.push_back(1); expWrD.push_back(chunkWord(0) & ~(32'h1 << 17));
    expWrA.push_back(1); expWrD.push_back(chunkWord(1) & ~(32'h1 << 17));
    expWords = '{32'hD000_0000, 32'hD000_0001, 32'hD000_0100, 32'hD000_0101};
    run(16'h0002, 16'h0005, 16, 1'b1, 1'b0, 2'd0, 10'h0, "R7");

    // R5: chunk larger than remaining buffer is clamped
    devReset();
    nChunks = 1; chSize[0] = 5; chLast[0] = 0; chErr[0] = 0;
    expWrA.push_back(1); expWrD.push_back(32'd3);
    expWrA.push_back(0); expWrD.push_back(32'h0001_0002);
    expWrA.push_back(1); expWrD.push_back(chunkWord(0) & ~(32'h1 << 17));
    expWords = '{32'hD000_0000, 32'hD000_0001, 32'hD000_0002};
    run(16'h0002, 16'h0001, 12, 1'b1, 1'b0, 2'd0, 10'h0, "R5");

    // R6: device drops in-progress early, no write-back
    devReset();
    nChunks = 1; opHoldAfter = 1; chSize[0] = 2; chLast[0] = 1; chErr[0] = 0;
    expWrA.push_back(1); expWrD.push_back(32'd8);
    expWrA.push_back(0); expWrD.push_back(32'h0003_0002);
    expWords = '{32'hD000_0000, 32'hD000_0001};
    run(16'h0002, 16'h0003, 32, 1'b1, 1'b0, 2'd0, 10'h0, "R6");

    // R4: device error code reported
    devReset();
    nChunks = 1; chSize[0] = 3; chLast[0] = 0; chErr[0] = 10'h2A5;
    expWrA.push_back(1); expWrD.push_back(32'd2);
    expWrA.push_back(0); expWrD.push_back(32'h0000_0002);
    run(16'h0002, 16'h0000, 8, 1'b1, 1'b0, 2'd2, 10'h2A5, "R4");

    // R6: message gets one acknowledge, size field ignored, write-back once
    devReset();
    nChunks = 1; opHoldAfter = 1; chSize[0] = 4; chLast[0] = 0; chErr[0] = 0;
    expWrA.push_back(1); expWrD.push_back(32'd0);
    expWrA.push_back(0); expWrD.push_back(32'h0000_0003);
    expWrA.push_back(1); expWrD.push_back(chunkWord(0) & ~(32'h1 << 17));
    run(16'h0003, 16'h0000, 12, 1'b0, 1'b0, 2'd0, 10'h0, "R6");

    // R9: legacy single-register exchange, queue index not sent
    devReset();
    opHold = 2; opHoldAfter = 3;
    expWrA.push_back(0); expWrD.push_back(32'h0000_0004);
    run(16'h0004, 16'h0007, 0, 1'b0, 1'b1, 2'd0, 10'h0, "R9");
    check(opPolls == 7, "R9", "command polls", 32'(opPolls), 32'd7);
    check(gapViol == 0, "R8", "poll spacing legacy", 32'(gapViol), 32'h0);

    // R7: zero-length payload goes straight to the final wait
    devReset();
    opHoldAfter = 1;
    expWrA.push_back(1); expWrD.push_back(32'd0);
    expWrA.push_back(0); expWrD.push_back(32'h0002_0002);
    run(16'h0002, 16'h0002, 0, 1'b1, 1'b0, 2'd0, 10'h0, "R7");
    check(opPolls == 2, "R7", "final wait polls", 32'(opPolls), 32'd2);

    // R8: command word never clears, timeout
    devReset();
    nChunks = 1; opHoldAfter = 1000000; chSize[0] = 1; chLast[0] = 1; chErr[0] = 0;
    expWrA.push_back(1); expWrD.push_back(32'd1);
    expWrA.push_back(0); expWrD.push_back(32'h0000_0002);
    expWords = '{32'hD000_0000};
    run(16'h0002, 16'h0000, 4, 1'b1, 1'b0, 2'd1, 10'h0, "R8");
    check(gapViol == 0, "R8", "poll spacing", 32'(gapViol), 32'h0);
    check(opPolls >= 2 && opPolls <= TO / GAP + 1, "R8", "poll count", 32'(opPolls), 32'(TO / GAP));
    check(reqReady == 1'b1, "R10", "ready after timeout", 32'(reqReady), 32'h1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule